// File: doc/BRIEF.md
# Dual-Mode Serial Transmit Engine

This block turns a parallel byte, with an optional ninth bit, into a serial stream on one data pin. It has three modes. In asynchronous mode it sends framed characters on a line that idles high. In synchronous master mode it drives a shift clock from its own baud divider. In synchronous slave mode it shifts on a clock supplied from outside. A single 8-bit control register sets the mode, the clock source, the frame width, the transmit enable and the baud speed. The same register reports whether the shift register is empty.

Software writes the control register, sets a baud divisor and writes bytes into a one-entry holding register. A byte written while the shifter is idle starts at once. A byte written while a frame is in flight waits in the holding register and goes out directly after that frame. In synchronous mode, an active receive enable blocks new transmissions. A global serial enable gates the pins and aborts any frame in flight.

The state machine has five states. ST_IDLE leaves on a load: to ST_START in asynchronous mode, or to ST_SYNC_BIT in synchronous mode. ST_START moves to ST_DATA at the end of the bit. ST_DATA loops on itself until the last data bit, then moves to ST_STOP. ST_STOP goes back to ST_START or ST_SYNC_BIT when a queued byte loads, and otherwise to ST_IDLE. ST_SYNC_BIT loops on itself until the last bit. After the last bit it reloads from the holding register or returns to ST_IDLE. Deasserting the serial enable forces ST_IDLE from any state.

Top module: `usart_tx_engine`

## Requirements
- R1: After reset the control register reads 0x02, the data pin is high and the clock pin is not driven.
- R2: Control bits 7 (clock master), 6 (nine-bit frames), 5 (transmit on), 4 (synchronous), 2 (fast baud) and 0 (ninth data bit) are writable. Bit 3 always reads 0. Bit 1 is the read-only shift-empty flag, and writes do not change it.
- R3: An asynchronous frame is a 0 start bit, then the data bits LSB first, then a 1 stop bit. The data pin is high whenever the shifter is empty.
- R4: In asynchronous mode each bit lasts (baud_div+1)*16 clocks when bit 2 is 0, and (baud_div+1)*4 clocks when bit 2 is 1.
- R5: When bit 6 is set, frames carry nine data bits and the ninth bit is taken from bit 0. When bit 6 is clear, frames carry eight data bits.
- R6: A byte written while a frame is in flight is held. It starts immediately after that frame's stop bit, with no idle gap. A write in the same cycle that a queued byte loads is itself queued and not lost.
- R7: Bit 1 reads 0 from the cycle a byte is loaded until its last bit completes, and reads 1 otherwise.
- R8: In synchronous master mode (bits 7 and 4 set) the clock pin is driven. It is low for the first half of each bit and high for the second half. A bit lasts (baud_div+1)*4 clocks whatever bit 2 holds. Data goes out LSB first and is stable at each rising clock edge.
- R9: In synchronous slave mode (bit 4 set, bit 7 clear) the clock pin is not driven. Data advances only on a falling edge of sck_in that follows a rising edge, after a two-flop synchroniser. The pin holds its bit while sck_in is still.
- R10: In synchronous mode, while rx_single_en or rx_cont_en is high, no frame starts. A queued byte starts once both are low.
- R11: While serial_en is low the data pin stays high, the clock pin is not driven and no frame runs. In asynchronous mode bit 7 has no effect on the clock pin.
- R12: While bit 5 is 0 no frame starts. A queued byte starts once bit 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serial_en | input | 1 | Global serial port enable |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value, including the shift-empty flag |
| baud_div | input | 8 | Baud divisor |
| data_we | input | 1 | Holding register write strobe |
| data_wdata | input | 8 | Byte to transmit |
| rx_single_en | input | 1 | Single-receive enable (blocks transmission in synchronous mode) |
| rx_cont_en | input | 1 | Continuous-receive enable (blocks transmission in synchronous mode) |
| sck_in | input | 1 | External shift clock for slave mode |
| sck_out | output | 1 | Shift clock driven in master mode |
| sck_oe | output | 1 | Output enable for the clock pin |
| txd_out | output | 1 | Serial data pin |

## Verification
The hard case is the end of one frame meeting a holding-register write in the same cycle. At that edge the queued byte moves into the shifter and a new byte must be captured into the emptied holding register. The bench waits for the first byte to start and queues a second byte. It then counts clocks so that a third write lands exactly on the edge where the first stop bit ends. The scoreboard expects all three bytes in order. It also expects the start of each following frame exactly half a bit after the sampled middle of the previous stop bit.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_SYNC_BIT
    } tx_state_e;

    typedef struct packed {
        logic clk_master;
        logic nine_bit;
        logic tx_on;
        logic sync_mode;
        logic fast_baud;
        logic ninth_data;
    } tx_ctl_t;

    localparam int CTL_W = 8;

endpackage

// File: rtl/usart_ctl_reg.sv
module usart_ctl_reg
    import usart_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    input  logic             shift_empty,
    output tx_ctl_t          ctl,
    output logic [CTL_W-1:0] rdata
);

    tx_ctl_t ctl_q;
    logic    unused_wbits;

    assign unused_wbits = wdata[3] ^ wdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (we) begin
            ctl_q.clk_master <= wdata[7];
            ctl_q.nine_bit   <= wdata[6];
            ctl_q.tx_on      <= wdata[5];
            ctl_q.sync_mode  <= wdata[4];
            ctl_q.fast_baud  <= wdata[2];
            ctl_q.ninth_data <= wdata[0];
        end
    end

    assign ctl   = ctl_q;
    assign rdata = {ctl_q.clk_master, ctl_q.nine_bit, ctl_q.tx_on, ctl_q.sync_mode,
                    1'b0, ctl_q.fast_baud, shift_empty, ctl_q.ninth_data};

endmodule

// File: rtl/usart_baud_gen.sv
module usart_baud_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fast4,
    input  logic [DIV_W-1:0] div,
    output logic             bit_tick,
    output logic             first_half
);

    localparam int SLOW_SUB = 16;
    localparam int FAST_SUB = 4;
    localparam int SUB_W    = $clog2(SLOW_SUB);

    logic [DIV_W-1:0] pre_q;
    logic [SUB_W-1:0] sub_q;
    logic [SUB_W-1:0] sub_last;
    logic [SUB_W-1:0] sub_half;
    logic             pre_wrap;

    assign sub_last = fast4 ? SUB_W'(FAST_SUB - 1) : SUB_W'(SLOW_SUB - 1);
    assign sub_half = fast4 ? SUB_W'(FAST_SUB / 2) : SUB_W'(SLOW_SUB / 2);
    assign pre_wrap = (pre_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            sub_q <= '0;
        end else if (!run) begin
            pre_q <= '0;
            sub_q <= '0;
        end else if (pre_wrap) begin
            pre_q <= '0;
            sub_q <= (sub_q >= sub_last) ? '0 : sub_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign bit_tick   = run && pre_wrap && (sub_q >= sub_last);
    assign first_half = sub_q < sub_half;

endmodule

// File: rtl/usart_edge_sync.sv
module usart_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);

    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], async_in};
        end
    end

    assign rise =  chain_q[STAGES-1] && !chain_q[STAGES];
    assign fall = !chain_q[STAGES-1] &&  chain_q[STAGES];

endmodule

// File: rtl/usart_tx_fsm.sv
module usart_tx_fsm
    import usart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              go,
    input  logic              hold_valid,
    input  logic [DATA_W-1:0] hold_data,
    input  tx_ctl_t           ctl,
    input  logic              bit_tick,
    input  logic              first_half,
    input  logic              ext_rise,
    input  logic              ext_fall,
    output logic              load,
    output logic              shift_empty,
    output logic              baud_run,
    output logic              baud_fast4,
    output logic              txd,
    output logic              sck_level
);

    localparam int SH_W  = DATA_W + 1;
    localparam int CNT_W = $clog2(DATA_W + 2);

    tx_state_e        state_q, state_d;
    logic [SH_W-1:0]  shreg_q;
    logic [CNT_W-1:0] cnt_q;
    logic             f_sync_q, f_master_q, f_nine_q;
    logic             rose_seen_q;
    logic             last_bit;
    logic             sync_bit_end;
    logic             frame_done;
    tx_state_e        load_target;

    assign last_bit     = (cnt_q == (f_nine_q ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1)));
    assign sync_bit_end = f_master_q ? bit_tick : (ext_fall && rose_seen_q);
    assign frame_done   = ((state_q == ST_STOP) && bit_tick) ||
                          ((state_q == ST_SYNC_BIT) && sync_bit_end && last_bit);
    assign load         = !abort && go && hold_valid &&
                          ((state_q == ST_IDLE) || frame_done);
    assign load_target  = ctl.sync_mode ? ST_SYNC_BIT : ST_START;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load) state_d = load_target;
            end
            ST_START: begin
                if (bit_tick) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_tick && last_bit) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (bit_tick) state_d = load ? load_target : ST_IDLE;
            end
            ST_SYNC_BIT: begin
                if (sync_bit_end && last_bit) state_d = load ? load_target : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort) state_d = ST_IDLE;
    end

    // datapath: shifter, bit counter, frame attributes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q     <= '0;
            cnt_q       <= '0;
            f_sync_q    <= 1'b0;
            f_master_q  <= 1'b0;
            f_nine_q    <= 1'b0;
            rose_seen_q <= 1'b0;
        end else if (abort) begin
            cnt_q       <= '0;
            rose_seen_q <= 1'b0;
        end else if (load) begin
            shreg_q     <= {ctl.ninth_data, hold_data};
            cnt_q       <= '0;
            f_sync_q    <= ctl.sync_mode;
            f_master_q  <= ctl.clk_master;
            f_nine_q    <= ctl.nine_bit;
            rose_seen_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_DATA: begin
                    if (bit_tick) begin
                        shreg_q <= shreg_q >> 1;
                        cnt_q   <= cnt_q + 1'b1;
                    end
                end
                ST_SYNC_BIT: begin
                    if (sync_bit_end) begin
                        shreg_q     <= shreg_q >> 1;
                        cnt_q       <= cnt_q + 1'b1;
                        rose_seen_q <= 1'b0;
                    end else if (ext_rise) begin
                        rose_seen_q <= 1'b1;
                    end
                end
                ST_IDLE, ST_START, ST_STOP: begin
                    rose_seen_q <= 1'b0;
                end
                default: begin
                    rose_seen_q <= 1'b0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        txd       = 1'b1;
        sck_level = 1'b1;
        unique case (state_q)
            ST_IDLE:     txd = 1'b1;
            ST_START:    txd = 1'b0;
            ST_DATA:     txd = shreg_q[0];
            ST_STOP:     txd = 1'b1;
            ST_SYNC_BIT: begin
                txd       = shreg_q[0];
                sck_level = !(f_master_q && first_half);
            end
            default:     txd = 1'b1;
        endcase
        shift_empty = (state_q == ST_IDLE);
        baud_run    = (state_q != ST_IDLE) && (!f_sync_q || f_master_q);
        baud_fast4  = f_sync_q || ctl.fast_baud;
    end

endmodule

// File: rtl/usart_tx_engine.sv
module usart_tx_engine
    import usart_tx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_en,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              rx_single_en,
    input  logic              rx_cont_en,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              txd_out
);

    tx_ctl_t           ctl;
    logic              shift_empty;
    logic              load;
    logic              go;
    logic              hold_valid_q;
    logic [DATA_W-1:0] hold_data_q;
    logic              bit_tick, first_half;
    logic              baud_run, baud_fast4;
    logic              ext_rise, ext_fall;
    logic              fsm_txd, fsm_sck;

    usart_ctl_reg u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (ctl_we),
        .wdata       (ctl_wdata),
        .shift_empty (shift_empty),
        .ctl         (ctl),
        .rdata       (ctl_rdata)
    );

    assign go = ctl.tx_on && !(ctl.sync_mode && (rx_single_en || rx_cont_en));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_valid_q <= 1'b0;
            hold_data_q  <= '0;
        end else begin
            hold_valid_q <= (hold_valid_q && !load) || data_we;
            if (data_we) hold_data_q <= data_wdata;
        end
    end

    usart_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (baud_run),
        .fast4      (baud_fast4),
        .div        (baud_div),
        .bit_tick   (bit_tick),
        .first_half (first_half)
    );

    usart_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sck_in),
        .rise     (ext_rise),
        .fall     (ext_fall)
    );

    usart_tx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort       (!serial_en),
        .go          (go),
        .hold_valid  (hold_valid_q),
        .hold_data   (hold_data_q),
        .ctl         (ctl),
        .bit_tick    (bit_tick),
        .first_half  (first_half),
        .ext_rise    (ext_rise),
        .ext_fall    (ext_fall),
        .load        (load),
        .shift_empty (shift_empty),
        .baud_run    (baud_run),
        .baud_fast4  (baud_fast4),
        .txd         (fsm_txd),
        .sck_level   (fsm_sck)
    );

    assign txd_out = serial_en ? fsm_txd : 1'b1;
    assign sck_out = fsm_sck;
    assign sck_oe  = serial_en && ctl.sync_mode && ctl.clk_master;

endmodule

// File: rtl/usart_tx_checker.sv
module usart_tx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       serial_en,
    input logic [7:0] ctl_rdata,
    input logic       rx_single_en,
    input logic       rx_cont_en,
    input logic       sck_oe,
    input logic       txd_out
);

    a_r3_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[1] |-> txd_out);

    a_r11_disabled_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_en |-> txd_out && !sck_oe);

    a_r11_disable_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_en |=> ctl_rdata[1]);

    a_r11_async_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[4] |-> !sck_oe);

    a_r8_master_drives_clock: assert property (@(posedge clk) disable iff (!rst_n)
        serial_en && ctl_rdata[4] && ctl_rdata[7] |-> sck_oe);

    a_r12_off_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[1] && !ctl_rdata[5] |=> ctl_rdata[1]);

    a_r10_rx_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[1] && ctl_rdata[4] && (rx_single_en || rx_cont_en) |=> ctl_rdata[1]);

endmodule

bind usart_tx_engine usart_tx_checker u_chk (.*);

// File: tb/tb_usart_tx_engine.sv
`timescale 1ns/1ps
module tb_usart_tx_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       serial_en = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic [7:0] baud_div = 8'd1;
    logic       data_we = 1'b0;
    logic [7:0] data_wdata = '0;
    logic       rx_single_en = 1'b0;
    logic       rx_cont_en = 1'b0;
    logic       sck_in = 1'b1;
    logic       sck_out, sck_oe, txd_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;
    logic [8:0] exp_q[$];

    localparam int NSLOW = 32;
    localparam int NFAST = 8;

    always #4 clk = ~clk;

    usart_tx_engine dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic ctl_write(input logic [7:0] v);
        ctl_wdata = v; ctl_we = 1'b1;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic data_write(input logic [7:0] v);
        data_wdata = v; data_we = 1'b1;
        @(negedge clk); data_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (ctl_rdata[1] !== 1'b1) @(negedge clk);
    endtask

    task automatic wait_busy();
        while (ctl_rdata[1] !== 1'b0) @(negedge clk);
    endtask

    // asynchronous monitor: checks framing and back-to-back spacing
    task automatic mon_async(input int nb, input int n, input int frames, input string tag);
        logic [8:0] got;
        logic [8:0] exp;
        int w;
        for (int f = 0; f < frames; f++) begin
            got = '0; w = 0;
            do begin @(negedge clk); w++; end while (txd_out !== 1'b0);
            if (f > 0) chk({tag, " R6 gap"}, w, n / 2);
            repeat (n / 2) @(negedge clk);
            chk({tag, " R3 start"}, txd_out, 0);
            for (int b = 0; b < nb; b++) begin
                repeat (n) @(negedge clk);
                got[b] = txd_out;
            end
            repeat (n) @(negedge clk);
            chk({tag, " R3 stop"}, txd_out, 1);
            exp = exp_q.pop_front();
            chk({tag, " R3 data"}, got, exp);
        end
    endtask

    // synchronous master monitor: samples on rising shift clock
    task automatic mon_master(input int nb, input int per, input string tag);
        logic [8:0] got;
        logic [8:0] exp;
        logic prev;
        int cyc, last_rise, k;
        got = '0; prev = sck_out; cyc = 0; last_rise = -1; k = 0;
        while (k < nb) begin
            @(negedge clk); cyc++;
            if (!prev && sck_out) begin
                got[k] = txd_out;
                if (last_rise >= 0) chk({tag, " R8 period"}, cyc - last_rise, per);
                last_rise = cyc;
                k++;
            end
            prev = sck_out;
        end
        exp = exp_q.pop_front();
        chk({tag, " R8 data"}, got, exp);
    endtask

    task automatic low_width(input logic [7:0] ctl, input int n, input string tag);
        int cnt;
        ctl_write(ctl);
        data_write(8'h01);
        while (txd_out !== 1'b0) @(negedge clk);
        cnt = 1;
        forever begin
            @(negedge clk);
            if (txd_out === 1'b0) cnt++; else break;
        end
        chk(tag, cnt, n);
        wait_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [8:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ctl reset", ctl_rdata, 8'h02);
        chk("R1 txd reset", txd_out, 1);
        chk("R1 sck_oe reset", sck_oe, 0);

        // R2 register fields
        ctl_write(8'hFF);
        chk("R2 readback all ones", ctl_rdata, 8'hF7);
        ctl_write(8'h00);
        chk("R2 readback zero", ctl_rdata, 8'h02);
        serial_en = 1'b1;

        // R3/R7 async low speed 8-bit
        ctl_write(8'h20);
        exp_q.push_back(9'h0A5);
        fork
            mon_async(8, NSLOW, 1, "async8");
            begin
                data_write(8'hA5);
                @(negedge clk);
                chk("R7 busy during frame", ctl_rdata[1], 0);
            end
        join
        wait_idle();
        chk("R7 empty after frame", ctl_rdata[1], 1);
        chk("R3 idle high", txd_out, 1);

        // R4 bit widths at both speeds
        low_width(8'h20, NSLOW, "R4 slow bit width");
        low_width(8'h24, NFAST, "R4 fast bit width");

        // R5 nine-bit frames
        ctl_write(8'h61);
        exp_q.push_back(9'h13C);
        fork mon_async(9, NSLOW, 1, "R5 ninth one"); data_write(8'h3C); join
        wait_idle();
        ctl_write(8'h60);
        exp_q.push_back(9'h0C3);
        fork mon_async(9, NSLOW, 1, "R5 ninth zero"); data_write(8'hC3); join
        wait_idle();

        // R6 queue, with a write landing on the load edge
        ctl_write(8'h24);
        exp_q.push_back(9'h011); exp_q.push_back(9'h022); exp_q.push_back(9'h0E7);
        fork
            mon_async(8, NFAST, 3, "R6 queue");
            begin
                data_write(8'h11);
                wait_busy();
                data_write(8'h22);
                repeat (10 * NFAST - 2) @(negedge clk);
                data_write(8'hE7);
            end
        join
        wait_idle();

        // R8 synchronous master, fast bit ignored
        ctl_write(8'hB0);
        chk("R8 clock driven", sck_oe, 1);
        exp_q.push_back(9'h096);
        fork mon_master(8, NFAST, "master"); data_write(8'h96); join
        wait_idle();
        ctl_write(8'hB4);
        exp_q.push_back(9'h05A);
        fork mon_master(8, NFAST, "master fast"); data_write(8'h5A); join
        wait_idle();

        // R10 receive enables block synchronous transmit
        ctl_write(8'hB0);
        rx_single_en = 1'b1;
        data_write(8'h33);
        repeat (40) @(negedge clk);
        chk("R10 single blocks", {ctl_rdata[1], txd_out, sck_out}, 3'b111);
        rx_single_en = 1'b0; rx_cont_en = 1'b1;
        repeat (40) @(negedge clk);
        chk("R10 cont blocks", {ctl_rdata[1], txd_out}, 2'b11);
        exp_q.push_back(9'h033);
        fork mon_master(8, NFAST, "R10 release"); rx_cont_en = 1'b0; join
        wait_idle();

        // R9 synchronous slave
        ctl_write(8'h30);
        chk("R9 clock not driven", sck_oe, 0);
        data_write(8'h6B);
        wait_busy();
        repeat (30) @(negedge clk);
        chk("R9 holds without clock", {ctl_rdata[1], txd_out}, 2'b01);
        got = '0;
        for (int k = 0; k < 8; k++) begin
            sck_in = 1'b0;
            repeat (8) @(negedge clk);
            got[k] = txd_out;
            sck_in = 1'b1;
            repeat (8) @(negedge clk);
        end
        chk("R9 slave data", got, 9'h06B);
        chk("R9 busy before last fall", ctl_rdata[1], 0);
        sck_in = 1'b0;
        repeat (8) @(negedge clk);
        chk("R9 empty after last fall", ctl_rdata[1], 1);
        sck_in = 1'b1;
        repeat (8) @(negedge clk);

        // R11 clock bit ignored in async, serial enable gating
        ctl_write(8'hA0);
        chk("R11 async no clock", sck_oe, 0);
        exp_q.push_back(9'h00F);
        fork mon_async(8, NSLOW, 1, "R11 async master bit"); data_write(8'h0F); join
        wait_idle();
        serial_en = 1'b0;
        ctl_write(8'hB0);
        chk("R11 disabled no clock", sck_oe, 0);
        ctl_write(8'h20);
        data_write(8'h55);
        repeat (60) @(negedge clk);
        chk("R11 disabled idle", {ctl_rdata[1], txd_out}, 2'b11);
        exp_q.push_back(9'h055);
        fork mon_async(8, NSLOW, 1, "R11 reenable"); serial_en = 1'b1; join
        wait_idle();

        // R12 transmit enable gating
        ctl_write(8'h00);
        data_write(8'h77);
        repeat (60) @(negedge clk);
        chk("R12 off idle", {ctl_rdata[1], txd_out}, 2'b11);
        exp_q.push_back(9'h077);
        fork mon_async(8, NSLOW, 1, "R12 on"); ctl_write(8'h20); join
        wait_idle();

        finish_run();
    end

endmodule